// File: doc/BRIEF.md
# Matrix Keyboard Scanner with Key FIFO

This block scans a keyboard matrix of up to 64 keys, laid out as eight drive rows by eight sense columns. A scan counter steps through the rows and holds each row for a fixed number of clock cycles. It drives the selected row on four scan lines, either as a plain binary count for an external decoder or as a one-of-four pattern decoded inside the block. At the end of each row slot the block samples the column inputs.

A closed key is accepted only after the same key reads closed on two consecutive scans of its row. The accepted key is then turned into an 8-bit code that also carries the state of the SHIFT and CONTROL inputs at that moment. The code is pushed into a small first-in first-out queue. The host reads this queue through an 8-bit read port with one address bit. Address 0 returns the oldest code and removes it from the queue. Address 1 returns a status byte that holds the entry count and an overrun flag.

An interrupt line signals a non-empty queue when interrupt mode is selected. In polled mode the host watches the count in the status byte instead.

Top module: `keyscan_ctrl`

## Requirements
- R1: With `scan_mode_i` = 0 (encoded), `scan_o` carries the current row number as a binary value in bits 2:0, with bit 3 = 0. Rows run 0 to 7 and then wrap to 0. Each row is held for `SCAN_DIV` clock cycles, and row 0 starts in the first cycle after reset.
- R2: With `scan_mode_i` = 1 (decoded), `scan_o` is one-hot: bit k is set for row k. Only rows 0 to 3 are scanned, each held for `SCAN_DIV` cycles, in increasing order with wrap. Keys in those rows are reported with their row number.
- R3: A key is stored only if its column reads closed at the end of its row slot on two consecutive scans. A closure that is seen on a single scan stores nothing.
- R4: A key that stays closed is stored once. A new entry for that key needs it to read open on at least one scan and then pass the two-scan test again.
- R5: A stored code has CONTROL in bit 7, SHIFT in bit 6, the row in bits 5:3 and the column in bits 2:0. The modifier bits are the values of `ctrl_i` and `shift_i` in the cycle the entry is stored.
- R6: At most one key is stored per row slot. When several keys in one row qualify, the lowest column is stored first and the others are stored on later scans.
- R7: The queue holds `FIFO_DEPTH` (8) codes in arrival order. A read strobe (`cs_i` = 1, `rd_i` = 1) with `a0_i` = 0 returns the oldest code on `data_o` in that cycle and removes it. On an empty queue such a read returns 0x00 and changes nothing.
- R8: When `a0_i` = 1, `data_o` is the status byte: the entry count in bits 3:0, the overrun flag in bit 5, and all other bits 0.
- R9: A key that qualifies while the queue is full, with no data read in the same cycle, is discarded and sets the overrun flag. A status read strobe clears the flag.
- R10: `irq_o` is 1 exactly when `int_mode_i` = 1 and the queue is not empty. When `int_mode_i` = 0, `irq_o` stays 0.
- R11: After reset the queue is empty, the overrun flag is clear, `irq_o` is 0 and the scan counter is at row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_mode_i | input | 1 | 0 selects the encoded scan output, 1 selects the decoded one-of-four output |
| int_mode_i | input | 1 | 1 enables the interrupt output, 0 selects polled operation |
| ret_i | input | 8 | Column sense lines for the scanned row, 1 = key closed |
| shift_i | input | 1 | SHIFT modifier state |
| ctrl_i | input | 1 | CONTROL modifier state |
| cs_i | input | 1 | Chip select, active high |
| rd_i | input | 1 | Read strobe, one cycle per read, active high |
| a0_i | input | 1 | 0 selects key data, 1 selects status |
| data_o | output | 8 | Read data: the oldest key code or the status byte |
| irq_o | output | 1 | Queue non-empty interrupt |
| scan_o | output | 4 | Scan lines, encoded or decoded |

## Verification
The scan output changes at the clock edge that ends each slot of `SCAN_DIV` cycles. The bench checks it at every falling edge against the row number it works out from the cycle count since reset, or since the first falling edge of a row-0 slot. A key's code enters the queue at the edge that ends its row slot on the second scan. The bench therefore starts every press at the beginning of a row-0 slot and waits at least three whole scans before it looks at the status byte and the interrupt. Read data and status are combinational, so the bench samples them one nanosecond after it raises the strobe. A removal or a flag clear takes effect at the next rising edge, so the bench looks for it at the following read.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    // Key code layout: the host decodes these field positions
    localparam int ROW_W  = 3;
    localparam int COL_W  = 3;
    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;
    localparam int SCAN_W = 4;
    localparam int CODE_W = 2 + ROW_W + COL_W;
    localparam int DEC_ROWS = 4;

    localparam int STAT_OVR_BIT = 5;

    typedef struct packed {
        logic             ctrl;
        logic             shift;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } key_code_t;

    typedef enum logic {
        SCAN_ENCODED = 1'b0,
        SCAN_DECODED = 1'b1
    } scan_mode_e;

    function automatic logic [SCAN_W-1:0] one_of_four(input logic [1:0] sel);
        logic [SCAN_W-1:0] v;
        v = '0;
        v[sel] = 1'b1;
        return v;
    endfunction

    function automatic logic [7:0] pack_status(input logic [3:0] cnt, input logic ovr);
        logic [7:0] s;
        s = '0;
        s[3:0] = cnt;
        s[STAT_OVR_BIT] = ovr;
        return s;
    endfunction

endpackage

// File: rtl/keyscan_counter.sv
module keyscan_counter
    import keyscan_pkg::*;
#(
    parameter int SCAN_DIV = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  scan_mode_e        mode_i,
    output logic [ROW_W-1:0]  row_o,
    output logic              slot_end_o,
    output logic [SCAN_W-1:0] scan_o
);
    localparam int DIV_W = (SCAN_DIV > 1) ? $clog2(SCAN_DIV) : 1;

    logic [DIV_W-1:0] div_q;
    logic [ROW_W-1:0] row_q;
    logic [ROW_W-1:0] last_row;

    assign slot_end_o = (div_q == DIV_W'(SCAN_DIV - 1));
    assign last_row   = (mode_i == SCAN_DECODED) ? ROW_W'(DEC_ROWS - 1) : ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            row_q <= '0;
        end else if (slot_end_o) begin
            div_q <= '0;
            row_q <= (row_q >= last_row) ? '0 : row_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign row_o = row_q;

    always_comb begin
        if (mode_i == SCAN_DECODED) begin
            scan_o = one_of_four(row_q[1:0]);
        end else begin
            scan_o = SCAN_W'(row_q);
        end
    end

endmodule

// File: rtl/keyscan_debounce.sv
module keyscan_debounce
    import keyscan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             slot_end_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [COLS-1:0]  ret_i,
    input  logic             shift_i,
    input  logic             ctrl_i,
    output logic             push_o,
    output key_code_t        code_o
);
    // Per-key history: closed on the previous scan, already reported
    logic [ROWS-1:0][COLS-1:0] seen_q;
    logic [ROWS-1:0][COLS-1:0] done_q;

    logic [COLS-1:0] qual;
    logic [COLS:0]   taken;
    logic [COLS-1:0] grant;
    logic [COL_W-1:0] pick_col;

    assign qual = ret_i & seen_q[row_i] & ~done_q[row_i];

    // Lowest column wins: a ripple of "already taken" below each column
    assign taken[0] = 1'b0;
    for (genvar c = 0; c < COLS; c++) begin : g_pick
        assign grant[c]   = qual[c] & ~taken[c];
        assign taken[c+1] = taken[c] | qual[c];
    end

    always_comb begin
        pick_col = '0;
        for (int c = 0; c < COLS; c++) begin
            if (grant[c]) pick_col = COL_W'(c);
        end
    end

    assign push_o = slot_end_i & taken[COLS];

    always_comb begin
        code_o.ctrl  = ctrl_i;
        code_o.shift = shift_i;
        code_o.row   = row_i;
        code_o.col   = pick_col;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            done_q <= '0;
        end else if (slot_end_i) begin
            seen_q[row_i] <= ret_i;
            done_q[row_i] <= (done_q[row_i] & ret_i) | grant;
        end
    end

endmodule

// File: rtl/keyscan_fifo.sv
module keyscan_fifo
    import keyscan_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push_i,
    input  logic [CODE_W-1:0]          data_i,
    input  logic                       pop_req_i,
    input  logic                       stat_rd_i,
    output logic [CODE_W-1:0]          head_o,
    output logic [$clog2(DEPTH+1)-1:0] cnt_o,
    output logic                       ovr_o
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CODE_W-1:0] mem_q [DEPTH];
    logic [AW-1:0]     wr_q, rd_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ovr_q;
    logic              pop, full, accept;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign pop    = pop_req_i && (cnt_q != '0);
    assign accept = push_i && (!full || pop);

    always_ff @(posedge clk) begin
        if (accept) mem_q[wr_q] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovr_q <= 1'b0;
        end else begin
            if (accept) wr_q <= bump(wr_q);
            if (pop)    rd_q <= bump(rd_q);
            cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(pop);
            if (push_i && !accept) begin
                ovr_q <= 1'b1;
            end else if (stat_rd_i) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign head_o = mem_q[rd_q];
    assign cnt_o  = cnt_q;
    assign ovr_o  = ovr_q;

endmodule

// File: rtl/keyscan_ctrl.sv
module keyscan_ctrl
    import keyscan_pkg::*;
#(
    parameter int SCAN_DIV   = 16,
    parameter int FIFO_DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scan_mode_i,
    input  logic       int_mode_i,
    input  logic [7:0] ret_i,
    input  logic       shift_i,
    input  logic       ctrl_i,
    input  logic       cs_i,
    input  logic       rd_i,
    input  logic       a0_i,
    output logic [7:0] data_o,
    output logic       irq_o,
    output logic [3:0] scan_o
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    scan_mode_e        mode;
    logic [ROW_W-1:0]  cur_row;
    logic              slot_end;
    logic              key_push;
    key_code_t         key_code;
    logic [CODE_W-1:0] head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              ovr_flag;
    logic              strobe;

    assign mode   = scan_mode_e'(scan_mode_i);
    assign strobe = cs_i & rd_i;

    keyscan_counter #(.SCAN_DIV(SCAN_DIV)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .mode_i     (mode),
        .row_o      (cur_row),
        .slot_end_o (slot_end),
        .scan_o     (scan_o)
    );

    keyscan_debounce u_deb (
        .clk        (clk),
        .rst        (rst),
        .slot_end_i (slot_end),
        .row_i      (cur_row),
        .ret_i      (ret_i),
        .shift_i    (shift_i),
        .ctrl_i     (ctrl_i),
        .push_o     (key_push),
        .code_o     (key_code)
    );

    keyscan_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst        (rst),
        .push_i     (key_push),
        .data_i     (CODE_W'(key_code)),
        .pop_req_i  (strobe & ~a0_i),
        .stat_rd_i  (strobe & a0_i),
        .head_o     (head),
        .cnt_o      (fifo_cnt),
        .ovr_o      (ovr_flag)
    );

    always_comb begin
        if (a0_i) begin
            data_o = pack_status(4'(fifo_cnt), ovr_flag);
        end else if (fifo_cnt == '0) begin
            data_o = 8'h00;
        end else begin
            data_o = 8'(head);
        end
    end

    assign irq_o = int_mode_i & (fifo_cnt != '0);

endmodule

// File: rtl/keyscan_checks.sv
module keyscan_checks #(
    parameter int FIFO_DEPTH = 8
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          scan_mode_i,
    input logic                          int_mode_i,
    input logic                          irq_o,
    input logic [3:0]                    scan_o,
    input logic                          cs_i,
    input logic                          rd_i,
    input logic                          a0_i,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
    input logic                          ovr,
    input logic                          push
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    a_r10_polled_quiet: assert property (@(posedge clk) disable iff (rst)
        !int_mode_i |-> !irq_o);

    a_r2_decoded_onehot: assert property (@(posedge clk) disable iff (rst)
        scan_mode_i |-> $onehot(scan_o));

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));

    a_r9_overrun_when_full: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(fifo_cnt) == CNT_W'(FIFO_DEPTH));

    a_r7_read_removes: assert property (@(posedge clk) disable iff (rst)
        (cs_i && rd_i && !a0_i && fifo_cnt != '0 && !push)
        |=> fifo_cnt == CNT_W'($past(fifo_cnt) - 1'b1));

    a_r9_status_clears: assert property (@(posedge clk) disable iff (rst)
        (cs_i && rd_i && a0_i && !(push && fifo_cnt == CNT_W'(FIFO_DEPTH))) |=> !ovr);

endmodule

bind keyscan_ctrl keyscan_checks #(.FIFO_DEPTH(FIFO_DEPTH)) u_checks (
    .clk         (clk),
    .rst         (rst),
    .scan_mode_i (scan_mode_i),
    .int_mode_i  (int_mode_i),
    .irq_o       (irq_o),
    .scan_o      (scan_o),
    .cs_i        (cs_i),
    .rd_i        (rd_i),
    .a0_i        (a0_i),
    .fifo_cnt    (fifo_cnt),
    .ovr         (ovr_flag),
    .push        (key_push)
);

// File: tb/sim_keyscan_ctrl.sv
`timescale 1ns/1ps
module sim_keyscan_ctrl;
    localparam int DIV  = 4;
    localparam int SCAN = 8 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_mode = 1'b0;
    logic       int_mode = 1'b1;
    logic [7:0] ret;
    logic       shift = 1'b0;
    logic       ctrl = 1'b0;
    logic       cs = 1'b0;
    logic       rd = 1'b0;
    logic       a0 = 1'b1;
    logic [7:0] data;
    logic       irq;
    logic [3:0] scan;

    logic [7:0] mat [8];
    logic [2:0] cur_row;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    keyscan_ctrl #(.SCAN_DIV(DIV), .FIFO_DEPTH(8)) u0 (
        .clk(clk), .rst(rst), .scan_mode_i(scan_mode), .int_mode_i(int_mode),
        .ret_i(ret), .shift_i(shift), .ctrl_i(ctrl), .cs_i(cs), .rd_i(rd),
        .a0_i(a0), .data_o(data), .irq_o(irq), .scan_o(scan)
    );

    // Matrix model: the row is taken from the scan lines
    always_comb begin
        cur_row = 3'd0;
        if (!scan_mode) begin
            cur_row = scan[2:0];
        end else begin
            for (int i = 0; i < 4; i++) if (scan[i]) cur_row = 3'(i);
        end
        ret = mat[cur_row];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] kc(input logic c, input logic s, input int r, input int col);
        return {c, s, 3'(r), 3'(col)};
    endfunction

    function automatic logic [7:0] st(input int cnt, input logic ovr);
        return {2'b00, ovr, 1'b0, 4'(cnt)};
    endfunction

    task automatic bus_read(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; a0 = sel;
        #1 d = data;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0; a0 = 1'b1;
    endtask

    task automatic peek_status(output logic [7:0] d);
        @(negedge clk);
        a0 = 1'b1;
        #1 d = data;
    endtask

    task automatic wait_row(input int r);
        while (cur_row == 3'(r)) @(negedge clk);
        while (cur_row != 3'(r)) @(negedge clk);
    endtask

    task automatic wait_scans(input int n);
        repeat (n * SCAN) @(negedge clk);
    endtask

    task automatic clear_mat();
        for (int i = 0; i < 8; i++) mat[i] = 8'h00;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog all requirements actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] d;
        clear_mat();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        #1;
        chk("R11 status after reset", data, st(0, 1'b0));
        chk("R11 irq after reset", irq, 0);
        chk("R11 scan row 0 after reset", scan, 0);

        // R1 encoded sweep from the first cycle after reset
        for (int k = 0; k < 2 * SCAN; k++) begin
            chk("R1 encoded scan lines", scan, (k / DIV) % 8);
            @(negedge clk);
        end

        // R2 decoded sweep
        scan_mode = 1'b1;
        wait_row(0);
        for (int k = 0; k < 3 * 4 * DIV; k++) begin
            chk("R2 decoded scan lines", scan, 1 << ((k / DIV) % 4));
            @(negedge clk);
        end
        scan_mode = 1'b0;
        wait_scans(1);

        // R3 R5 R8 R10 single key with SHIFT
        shift = 1'b1; ctrl = 1'b0;
        wait_row(0);
        mat[3][5] = 1'b1;
        wait_scans(3);
        peek_status(d);
        chk("R8 count after one key", d, st(1, 1'b0));
        chk("R10 irq with data", irq, 1);
        bus_read(1'b0, d);
        chk("R5 R3 code with shift", d, kc(1'b0, 1'b1, 3, 5));
        peek_status(d);
        chk("R7 entry removed", d, st(0, 1'b0));
        chk("R10 irq drops when empty", irq, 0);

        // R4 held key stored once
        wait_scans(3);
        peek_status(d);
        chk("R4 held key not repeated", d, st(0, 1'b0));

        // R4 release then press again with CONTROL
        clear_mat();
        wait_scans(2);
        shift = 1'b0; ctrl = 1'b1;
        wait_row(0);
        mat[3][5] = 1'b1;
        wait_scans(3);
        bus_read(1'b0, d);
        chk("R4 R5 re-press with ctrl", d, kc(1'b1, 1'b0, 3, 5));
        clear_mat();
        wait_scans(2);
        ctrl = 1'b0;

        // R3 closure seen on one scan only
        wait_row(2);
        mat[2][4] = 1'b1;
        while (cur_row == 3'd2) @(negedge clk);
        clear_mat();
        wait_scans(3);
        peek_status(d);
        chk("R3 single-scan closure dropped", d, st(0, 1'b0));

        // R6 two keys in one row
        wait_row(0);
        mat[4][6] = 1'b1;
        mat[4][1] = 1'b1;
        wait_scans(4);
        peek_status(d);
        chk("R6 both keys stored", d, st(2, 1'b0));
        bus_read(1'b0, d);
        chk("R6 lowest column first", d, kc(1'b0, 1'b0, 4, 1));
        bus_read(1'b0, d);
        chk("R6 higher column next", d, kc(1'b0, 1'b0, 4, 6));
        clear_mat();
        wait_scans(2);

        // R10 polled mode
        int_mode = 1'b0;
        wait_row(0);
        mat[1][2] = 1'b1;
        wait_scans(3);
        chk("R10 no irq in polled mode", irq, 0);
        peek_status(d);
        chk("R10 R8 polled status count", d, st(1, 1'b0));
        bus_read(1'b0, d);
        chk("R10 polled read code", d, kc(1'b0, 1'b0, 1, 2));
        clear_mat();
        wait_scans(2);
        int_mode = 1'b1;

        // R7 read on empty queue
        bus_read(1'b0, d);
        chk("R7 empty read value", d, 8'h00);
        peek_status(d);
        chk("R7 empty read leaves count", d, st(0, 1'b0));

        // R9 overrun: nine keys, the ninth dropped
        wait_row(0);
        for (int r = 0; r < 8; r++) mat[r][0] = 1'b1;
        mat[0][1] = 1'b1;
        wait_scans(5);
        bus_read(1'b1, d);
        chk("R9 overrun flag and full count", d, st(8, 1'b1));
        peek_status(d);
        chk("R9 status read clears overrun", d, st(8, 1'b0));
        for (int r = 0; r < 8; r++) begin
            bus_read(1'b0, d);
            chk("R7 R9 arrival order kept", d, kc(1'b0, 1'b0, r, 0));
        end
        peek_status(d);
        chk("R7 drained", d, st(0, 1'b0));
        clear_mat();
        wait_scans(2);

        // R2 key in decoded mode
        scan_mode = 1'b1;
        wait_scans(1);
        wait_row(0);
        mat[2][3] = 1'b1;
        wait_scans(3);
        bus_read(1'b0, d);
        chk("R2 R5 decoded-mode key code", d, kc(1'b0, 1'b0, 2, 3));
        peek_status(d);
        chk("R2 single entry in decoded mode", d, st(0, 1'b0));
        clear_mat();

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule